// File: doc/BRIEF.md
# D-Channel Status Register With Clear-On-Read

This block is a byte-wide, read-only status register for a serial line interface with four ports. For each port it holds a sticky flag that records whether a D-channel byte other than the idle all-ones pattern has been received. For the first two ports it also shows whether the D channel is currently granted. The grant source depends on the interface mode. In direct mode the grant comes straight from an external grant pin. In inverted mode it is the complement of the port's SCIT bit. In both modes a set grant bit means the D channel may be used.

Software reads the register through a single read strobe. The read data is registered and is valid one cycle after the strobe. The same clock edge clears every flag. A change event that arrives on that edge is kept, so no event is lost. The grant bits are sampled again from the live inputs on the next clock edge. Both a hardware reset and a software reset clear all state.

Top module: `dchan_status_reg`

## Requirements
- R1: The register is 8 bits wide. Bits 7 and 6 always read as zero.
- R2: A load strobe on port p (0..3) whose byte is not 0xFF sets change flag bit p. This flag is visible to any read strobe issued on a later edge.
- R3: A load strobe whose byte is exactly 0xFF leaves the change flags unchanged. A byte presented without its strobe is also ignored.
- R4: A set change flag stays set, whatever later idle bytes arrive, until a read, a hardware reset or a software reset clears it.
- R5: With grant_mode = 0 (direct), bit 4 + g (g = 0, 1) follows grant_in[g] as sampled at each clock edge with no read. The scit_in input has no effect in this mode.
- R6: With grant_mode = 1 (inverted), bit 4 + g follows the inverse of scit_in[g]. The grant_in input has no effect in this mode.
- R7: A read strobe sampled at an edge loads rd_data with the register value held just before that edge. rd_data keeps that value until the next read strobe or reset.
- R8: The edge that samples a read strobe clears all flags. A second read on the very next edge therefore returns zero grant bits. The grant bits are evaluated again from the live inputs one edge later.
- R9: If a non-idle load and a read strobe fall on the same edge, the read returns the old value and the new change flag stays set for the next read.
- R10: A hardware reset (rst, synchronous, active high) clears the register and rd_data.
- R11: A software reset strobe (soft_rst) clears the register and rd_data on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset strobe, one cycle |
| rx_byte | input | 32 | Received D-channel bytes; port p on bits 8p+7..8p |
| rx_load | input | 4 | Per-port load strobe for rx_byte |
| grant_in | input | 2 | External grant inputs for ports 0 and 1 (direct mode) |
| scit_in | input | 2 | SCIT bits for ports 0 and 1 (inverted mode) |
| grant_mode | input | 1 | 0 = direct grant, 1 = inverted SCIT |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
Events that occur at an edge before the read edge are seen by the read. This includes a change flag set by a load and a grant bit sampled from the live inputs. The read value itself is in rd_data one cycle after the strobe. The bench drives inputs just after a falling edge and samples rd_data on the next falling edge. Each vector therefore spends one edge loading, one idle edge and one read edge before it compares. The directed cases place a read on the edge right after another read to expose the one-edge gap in grant re-evaluation. They also place a load on the same edge as a read to check that no event is lost.

// File: rtl/dchan_stat_pkg.sv
package dchan_stat_pkg;

  // Source of a port's grant indication
  typedef enum logic {
    GSRC_DIRECT = 1'b0,  // external grant pin, active high
    GSRC_INVERT = 1'b1   // complement of the SCIT bit
  } grant_src_e;

  // A received byte counts as activity unless it equals the idle pattern
  function automatic logic byte_is_active(input logic [7:0] b,
                                          input logic [7:0] idle);
    return (b != idle);
  endfunction

endpackage

// File: rtl/dchan_change_flag.sv
module dchan_change_flag
  import dchan_stat_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  IDLE_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              clr,
  output logic              flag
);

  logic set_evt;

  always_comb begin
    set_evt = load && byte_is_active(rx_byte[7:0], IDLE_VAL);
  end

  // A set event wins over a clear so that an event coinciding with a read
  // survives into the next read.
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assert_active_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (load && (rx_byte[7:0] != IDLE_VAL) && !soft_rst) |=> flag);

  assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!flag && !soft_rst && !(load && (rx_byte[7:0] != IDLE_VAL))) |=> !flag);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr && !soft_rst) |=> flag);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !(load && (rx_byte[7:0] != IDLE_VAL))) |=> !flag);

  assert_same_edge_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && load && (rx_byte[7:0] != IDLE_VAL) && !soft_rst) |=> flag);

endmodule

// File: rtl/dchan_grant_flag.sv
module dchan_grant_flag
  import dchan_stat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic mode,
  input  logic grant_pin,
  input  logic scit_bit,
  input  logic clr,
  output logic flag
);

  grant_src_e src;
  logic       live_grant;

  always_comb begin
    src = grant_src_e'(mode);
    unique case (src)
      GSRC_DIRECT: live_grant = grant_pin;
      GSRC_INVERT: live_grant = ~scit_bit;
      default:     live_grant = 1'b0;
    endcase
  end

  // A read clears the flag; the next edge without a read samples the live
  // grant again.
  always_ff @(posedge clk) begin
    if (rst || soft_rst || clr) begin
      flag <= 1'b0;
    end else begin
      flag <= live_grant;
    end
  end

  assert_direct_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !soft_rst && !mode) |=> (flag == $past(grant_pin)));

  assert_invert_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !soft_rst && mode) |=> (flag == !$past(scit_bit)));

  assert_grant_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);

endmodule

// File: rtl/dchan_read_port.sv
module dchan_read_port #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             rd_en,
  input  logic [REG_W-1:0] status,
  output logic [REG_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= status;
    end
  end

  assert_read_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !soft_rst) |=> (rd_data == $past(status)));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !soft_rst) |=> $stable(rd_data));

endmodule

// File: rtl/dchan_status_reg.sv
module dchan_status_reg
  import dchan_stat_pkg::*;
#(
  parameter int         NUM_PORTS = 4,
  parameter int         NUM_GRANT = 2,
  parameter int         BYTE_W    = 8,
  parameter int         REG_W     = 8,
  parameter logic [7:0] IDLE_VAL  = 8'hFF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          soft_rst,
  input  logic [NUM_PORTS*BYTE_W-1:0]   rx_byte,
  input  logic [NUM_PORTS-1:0]          rx_load,
  input  logic [NUM_GRANT-1:0]          grant_in,
  input  logic [NUM_GRANT-1:0]          scit_in,
  input  logic                          grant_mode,
  input  logic                          rd_en,
  output logic [REG_W-1:0]              rd_data
);

  // Change flags occupy the low bits, grant flags sit directly above them,
  // and anything left over is reserved and reads as zero.
  localparam int GRANT_LSB = NUM_PORTS;
  localparam int USED_BITS = NUM_PORTS + NUM_GRANT;

  logic [NUM_PORTS-1:0] chg_flags;
  logic [NUM_GRANT-1:0] gnt_flags;
  logic [REG_W-1:0]     status;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chg
    dchan_change_flag #(
      .BYTE_W   (BYTE_W),
      .IDLE_VAL (IDLE_VAL)
    ) u_chg (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst),
      .load     (rx_load[p]),
      .rx_byte  (rx_byte[p*BYTE_W +: BYTE_W]),
      .clr      (rd_en),
      .flag     (chg_flags[p])
    );
  end

  for (genvar g = 0; g < NUM_GRANT; g++) begin : g_gnt
    dchan_grant_flag u_gnt (
      .clk       (clk),
      .rst       (rst),
      .soft_rst  (soft_rst),
      .mode      (grant_mode),
      .grant_pin (grant_in[g]),
      .scit_bit  (scit_in[g]),
      .clr       (rd_en),
      .flag      (gnt_flags[g])
    );
  end

  always_comb begin
    status = '0;
    status[NUM_PORTS-1:0]            = chg_flags;
    status[GRANT_LSB +: NUM_GRANT]   = gnt_flags;
  end

  dchan_read_port #(
    .REG_W (REG_W)
  ) u_rdport (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .rd_en    (rd_en),
    .status   (status),
    .rd_data  (rd_data)
  );

  if (USED_BITS < REG_W) begin : g_rsvd_chk
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
      rd_data[REG_W-1:USED_BITS] == '0);
  end

  assert_hw_reset_R10: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && status == '0));

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (rd_data == '0 && status == '0));

endmodule

// File: tb/dchan_status_reg_tb_top.sv
module dchan_status_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // Vector fields: load[48:45] bytes[44:13] grant[12:11] scit[10:9]
  // mode[8] expected read[7:0]. Bytes: port3 in the top byte.
  localparam logic [48:0] VECS [NVEC] = '{
    {4'b0001, 32'hFFFF_FF00, 2'b00, 2'b11, 1'b0, 8'h01},
    {4'b1111, 32'hFFFF_FFFF, 2'b11, 2'b11, 1'b0, 8'h30},
    {4'b1010, 32'h12FF_34FF, 2'b01, 2'b11, 1'b0, 8'h1A},
    {4'b0100, 32'hFF7F_FFFF, 2'b00, 2'b10, 1'b1, 8'h14},
    {4'b1111, 32'h0001_FE80, 2'b00, 2'b00, 1'b1, 8'h3F},
    {4'b0000, 32'h0000_0000, 2'b11, 2'b11, 1'b1, 8'h00},
    {4'b1000, 32'hFF00_0000, 2'b10, 2'b11, 1'b0, 8'h20},
    {4'b0011, 32'hFFFF_0055, 2'b00, 2'b00, 1'b0, 8'h03}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [31:0] rx_byte = 32'hFFFF_FFFF;
  logic [3:0]  rx_load = '0;
  logic [1:0]  grant_in = '0;
  logic [1:0]  scit_in = 2'b11;
  logic        grant_mode = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchan_status_reg dut_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .rx_byte    (rx_byte),
    .rx_load    (rx_load),
    .grant_in   (grant_in),
    .scit_in    (scit_in),
    .grant_mode (grant_mode),
    .rd_en      (rd_en),
    .rd_data    (rd_data)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp,
                       input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Called right after a falling edge; samples on the next falling edge.
  task automatic do_read(input logic [7:0] exp, input string tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_data, 8'h00, "R10 reset rd_data");
    @(negedge clk);
    do_read(8'h00, "R10 reset status");

    // Vector table: load edge, idle edge, read edge
    for (int i = 0; i < NVEC; i++) begin
      rx_load    = VECS[i][48:45];
      rx_byte    = VECS[i][44:13];
      grant_in   = VECS[i][12:11];
      scit_in    = VECS[i][10:9];
      grant_mode = VECS[i][8];
      @(negedge clk);
      rx_load = '0;
      rx_byte = 32'hA5A5_A5A5;  // present without strobe: ignored (R3)
      @(negedge clk);
      do_read(VECS[i][7:0], $sformatf("R2 R5 R6 R1 vector %0d", i));
    end

    // R4: sticky flag survives idle bytes and waiting
    grant_in = '0; grant_mode = 1'b0;
    rx_load = 4'b0100; rx_byte = 32'hFF10_FFFF;
    @(negedge clk);
    rx_load = 4'b1111; rx_byte = 32'hFFFF_FFFF;
    @(negedge clk);
    rx_load = '0;
    repeat (5) @(negedge clk);
    do_read(8'h04, "R4 sticky change flag");
    do_read(8'h00, "R8 cleared after read");

    // R7: rd_data holds between reads
    rx_load = 4'b0001; rx_byte = 32'hFFFF_FF11;
    @(negedge clk);
    rx_load = '0;
    @(negedge clk);
    do_read(8'h01, "R7 capture");
    rx_load = 4'b1000; rx_byte = 32'h22FF_FFFF;
    @(negedge clk);
    rx_load = '0;
    repeat (3) @(negedge clk);
    check(rd_data, 8'h01, "R7 hold without read");
    do_read(8'h08, "R7 next read");

    // R8: grant cleared by read, re-evaluated one edge later
    grant_in = 2'b11;
    repeat (2) @(negedge clk);
    do_read(8'h30, "R8 grant before read");
    do_read(8'h00, "R8 back-to-back grant cleared");
    @(negedge clk);
    do_read(8'h30, "R8 grant re-evaluated");
    grant_in = '0;
    @(negedge clk);
    do_read(8'h00, "R8 grant drop");

    // R9: load and read on the same edge
    @(negedge clk);
    rx_load = 4'b0001; rx_byte = 32'hFFFF_FF3C;
    do_read(8'h00, "R9 read returns old value");
    rx_load = '0;
    do_read(8'h01, "R9 event kept");

    // R11: software reset
    rx_load = 4'b1000; rx_byte = 32'h00FF_FFFF;
    @(negedge clk);
    rx_load = '0;
    @(negedge clk);
    do_read(8'h08, "R11 setup");
    rx_load = 4'b0010; rx_byte = 32'hFFFF_01FF;
    @(negedge clk);
    rx_load = '0;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check(rd_data, 8'h00, "R11 rd_data cleared");
    do_read(8'h00, "R11 flags cleared");

    // R10: hardware reset mid-run
    rx_load = 4'b0001; rx_byte = 32'hFFFF_FF00;
    @(negedge clk);
    rx_load = '0;
    @(negedge clk);
    do_read(8'h01, "R10 setup");
    rx_load = 4'b0100; rx_byte = 32'hFF00_FFFF;
    @(negedge clk);
    rx_load = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rd_data, 8'h00, "R10 rd_data after reset");
    do_read(8'h00, "R10 flags after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule